// File: doc/BRIEF.md
# In-memory row copy sequencer

This block sits on the memory-controller side of a DRAM channel. It turns bulk copy and bulk zero-fill requests into command sequences that move whole rows inside the memory device, so no row data travels over the external data bus. Each request names a source bank and row, a destination bank and row, and a zero-fill flag. Row addresses are `{subarray, local_row}`, with the subarray in the upper bits. The block compares the coordinates and picks one of three strategies.

When source and destination share a subarray, the block issues two back-to-back activations. The second activation disconnects the source and writes the sensed row into the destination. When the banks differ, both rows are opened and the row moves over the shared internal bus in bursts, with reads and writes overlapped. When the bank is the same but the subarray differs, the row makes two inter-bank hops through a staging row in a neighbouring bank. A zero-fill is a same-subarray copy from the reserved all-zero row of the destination's subarray. Filling rows with an arbitrary value is done by writing one row through the normal path and then issuing copy requests from it.

Exactly one command is issued per cycle. After the last precharge, completion is signalled for one cycle.

Top module: `row_copy_seq`

## Requirements
- R1: For source and destination in the same bank and subarray, the commands are ACT(source row), ACT(destination row) in consecutive cycles with no PRE between them, then one PRE to that bank. `done` rises 4 cycles after the accepting edge.
- R2: After `done`, the destination row holds the source row's former contents. Every row other than the destination, and the staging row in mode R4, is unchanged.
- R3: For different banks, the commands are ACT(source), ACT(destination), then 2·N transfer commands (N = ROW_BYTES/BURST_BYTES). The order is RD0, RD1, WR0, RD2, WR1, …, RD(N-1), WR(N-2), WR(N-1), so at most two bursts are ever in flight. After that comes PRE(source bank), then PRE(destination bank). `done` rises 2·N+5 cycles after acceptance.
- R4: For the same bank and a different subarray, the row first moves by an R3 transfer into the staging row: bank `src_bank XOR 1`, subarray 0, local row ROWS_PER_SUB-1. It then moves by a second R3 transfer from there into the destination. `done` rises 4·N+9 cycles after acceptance.
- R5: With `req_zero`=1 the source fields are ignored. The destination is filled from local row 0 of its own subarray in the same bank, using the R1 sequence. Afterwards the destination reads as all zeros.
- R6: The mode is chosen only from the bank and subarray fields: different banks give R3, same bank and subarray give R1, same bank with a different subarray gives R4.
- R7: A request is rejected if its destination local row is 0 (zero row) or ROWS_PER_SUB-1 (staging row), or if it is a non-zero copy whose source equals its destination. A rejected request raises `err` for one cycle, in the cycle after acceptance. It issues no command and changes no row.
- R8: `done` lasts one cycle and `req_ready` is high in the following cycle. While a request is in progress `req_ready` is low, and a request presented then is neither accepted nor executed.
- R9: Out of reset, `req_ready`=1, `cmd_op`=NOP, `done`=0 and `err`=0. Command codes are NOP=0, ACT=1, PRE=2, RD=3, WR=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request accepted on this edge when valid |
| req_zero | input | 1 | Zero-fill request (source fields ignored) |
| req_src_bank | input | BW (2) | Source bank |
| req_src_row | input | RW (5) | Source row {subarray, local} |
| req_dst_bank | input | BW (2) | Destination bank |
| req_dst_row | input | RW (5) | Destination row {subarray, local} |
| cmd_op | output | 3 | Command code (NOP, ACT, PRE, RD, WR) |
| cmd_bank | output | BW (2) | Command bank |
| cmd_row | output | RW (5) | Row for ACT |
| cmd_col | output | CW (3) | Burst index for RD/WR |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The in-line assertions check these properties on every cycle:
- two consecutive activations to one bank never leave the subarray, and the second one never targets the zero row;
- a write burst always has a read burst in flight, and never more than two are in flight;
- no command appears while idle or rejecting;
- `done` is a single-cycle pulse followed by ready.

The bench's scenarios show the rest, using a row-buffer model of the device:
- that the data actually lands in the destination, and the staging row is updated in the two-hop case;
- the exact latencies per mode and the precharge order;
- that a request held during a busy period is ignored;
- that rejected requests leave all rows untouched.

// File: rtl/row_copy_pkg.sv
package row_copy_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        MODE_INTRA  = 2'd0,
        MODE_XBANK  = 2'd1,
        MODE_TWOHOP = 2'd2
    } copy_mode_e;

    typedef enum logic [2:0] {
        HS_IDLE, HS_ACT_SRC, HS_ACT_DST, HS_XFER, HS_PRE_SRC, HS_PRE_DST
    } hop_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_HOP1, SQ_HOP2, SQ_DONE, SQ_REJECT
    } seq_state_e;
endpackage

// File: rtl/row_copy_classify.sv
module row_copy_classify import row_copy_pkg::*; #(
    parameter int BW = 2,
    parameter int SW = 2,
    parameter int LW = 3,
    parameter int ROWS_PER_SUB = 8,
    localparam int RW = SW + LW
) (
    input  logic              zero,
    input  logic [BW-1:0]     src_bank,
    input  logic [RW-1:0]     src_row,
    input  logic [BW-1:0]     dst_bank,
    input  logic [RW-1:0]     dst_row,
    output copy_mode_e        mode,
    output logic              reject,
    output logic [BW-1:0]     eff_src_bank,
    output logic [RW-1:0]     eff_src_row,
    output logic [BW-1:0]     stage_bank,
    output logic [RW-1:0]     stage_row
);
    localparam logic [LW-1:0] ZERO_LOCAL  = '0;
    localparam logic [LW-1:0] STAGE_LOCAL = LW'(ROWS_PER_SUB - 1);

    logic [SW-1:0] src_sub, dst_sub;
    logic [LW-1:0] dst_local;
    logic          same_bank, same_sub, dst_reserved;

    always_comb begin
        src_sub      = src_row[RW-1:LW];
        dst_sub      = dst_row[RW-1:LW];
        dst_local    = dst_row[LW-1:0];
        same_bank    = (src_bank == dst_bank);
        same_sub     = (src_sub == dst_sub);
        dst_reserved = (dst_local == ZERO_LOCAL) || (dst_local == STAGE_LOCAL);
        stage_bank   = src_bank ^ BW'(1);
        stage_row    = {{SW{1'b0}}, STAGE_LOCAL};
        if (zero) begin
            mode         = MODE_INTRA;
            eff_src_bank = dst_bank;
            eff_src_row  = {dst_sub, ZERO_LOCAL};
            reject       = dst_reserved;
        end else begin
            eff_src_bank = src_bank;
            eff_src_row  = src_row;
            if (!same_bank)     mode = MODE_XBANK;
            else if (same_sub)  mode = MODE_INTRA;
            else                mode = MODE_TWOHOP;
            reject = dst_reserved || (same_bank && (src_row == dst_row));
        end
    end
endmodule

// File: rtl/row_copy_hop.sv
module row_copy_hop import row_copy_pkg::*; #(
    parameter int BW   = 2,
    parameter int RW   = 5,
    parameter int NCOL = 8,
    localparam int CW  = $clog2(NCOL),
    localparam int KW  = $clog2(2 * NCOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_xbank,
    input  logic [BW-1:0] start_sb,
    input  logic [RW-1:0] start_sr,
    input  logic [BW-1:0] start_db,
    input  logic [RW-1:0] start_dr,
    output cmd_op_e       cmd_op,
    output logic [BW-1:0] cmd_bank,
    output logic [RW-1:0] cmd_row,
    output logic [CW-1:0] cmd_col,
    output logic          last
);
    localparam logic [KW-1:0] LAST_STEP = KW'(2 * NCOL - 1);

    typedef struct packed {
        hop_state_e    st;
        logic          xbank;
        logic [BW-1:0] sb;
        logic [RW-1:0] sr;
        logic [BW-1:0] db;
        logic [RW-1:0] dr;
        logic [KW-1:0] step;
    } hop_regs_t;

    hop_regs_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            HS_ACT_SRC: d.st = HS_ACT_DST;
            HS_ACT_DST: begin
                d.st   = q.xbank ? HS_XFER : HS_PRE_SRC;
                d.step = '0;
            end
            HS_XFER: begin
                if (q.step == LAST_STEP) d.st = HS_PRE_SRC;
                else                     d.step = q.step + 1'b1;
            end
            HS_PRE_SRC: d.st = q.xbank ? HS_PRE_DST : HS_IDLE;
            HS_PRE_DST: d.st = HS_IDLE;
            default:    d.st = HS_IDLE;
        endcase
        if (start) begin
            d.st    = HS_ACT_SRC;
            d.xbank = start_xbank;
            d.sb    = start_sb;
            d.sr    = start_sr;
            d.db    = start_db;
            d.dr    = start_dr;
            d.step  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: HS_IDLE, xbank: 1'b0, sb: '0, sr: '0, db: '0, dr: '0, step: '0};
        end else begin
            q <= d;
        end
    end

    // Overlapped burst order: RD0, then odd steps read ahead, even steps write behind.
    logic [KW:0] half_up;
    always_comb begin
        half_up  = ({1'b0, q.step} + 1'b1) >> 1;
        cmd_op   = CMD_NOP;
        cmd_bank = '0;
        cmd_row  = '0;
        cmd_col  = '0;
        case (q.st)
            HS_ACT_SRC: begin cmd_op = CMD_ACT; cmd_bank = q.sb; cmd_row = q.sr; end
            HS_ACT_DST: begin cmd_op = CMD_ACT; cmd_bank = q.db; cmd_row = q.dr; end
            HS_PRE_SRC: begin cmd_op = CMD_PRE; cmd_bank = q.sb; end
            HS_PRE_DST: begin cmd_op = CMD_PRE; cmd_bank = q.db; end
            HS_XFER: begin
                if (!q.step[0]) begin
                    if (q.step == '0) begin
                        cmd_op = CMD_RD; cmd_bank = q.sb; cmd_col = '0;
                    end else begin
                        cmd_op = CMD_WR; cmd_bank = q.db;
                        cmd_col = CW'((q.step >> 1) - 1'b1);
                    end
                end else if (half_up < (KW+1)'(NCOL)) begin
                    cmd_op = CMD_RD; cmd_bank = q.sb; cmd_col = CW'(half_up);
                end else begin
                    cmd_op = CMD_WR; cmd_bank = q.db; cmd_col = CW'(NCOL - 1);
                end
            end
            default: ;
        endcase
        last = ((q.st == HS_PRE_SRC) && !q.xbank) || (q.st == HS_PRE_DST);
    end

    // Bursts on the internal bus not yet written back.
    logic [2:0] inflight_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  inflight_q <= '0;
        else if (q.st == HS_ACT_SRC) inflight_q <= '0;
        else if (cmd_op == CMD_RD)   inflight_q <= inflight_q + 1'b1;
        else if (cmd_op == CMD_WR)   inflight_q <= inflight_q - 1'b1;
    end

    assert_wr_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_WR) |-> (inflight_q != 3'd0));
    assert_pipe_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 3'd2);
endmodule

// File: rtl/row_copy_seq.sv
module row_copy_seq import row_copy_pkg::*; #(
    parameter int NUM_BANKS    = 4,
    parameter int SUBARRAYS    = 4,
    parameter int ROWS_PER_SUB = 8,
    parameter int ROW_BYTES    = 4096,
    parameter int BURST_BYTES  = 512,
    localparam int BW   = $clog2(NUM_BANKS),
    localparam int SW   = $clog2(SUBARRAYS),
    localparam int LW   = $clog2(ROWS_PER_SUB),
    localparam int RW   = SW + LW,
    localparam int NCOL = ROW_BYTES / BURST_BYTES,
    localparam int CW   = $clog2(NCOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_zero,
    input  logic [BW-1:0] req_src_bank,
    input  logic [RW-1:0] req_src_row,
    input  logic [BW-1:0] req_dst_bank,
    input  logic [RW-1:0] req_dst_row,
    output logic [2:0]    cmd_op,
    output logic [BW-1:0] cmd_bank,
    output logic [RW-1:0] cmd_row,
    output logic [CW-1:0] cmd_col,
    output logic          done,
    output logic          err
);
    copy_mode_e    cls_mode;
    logic          cls_reject;
    logic [BW-1:0] cls_sb, cls_stage_bank;
    logic [RW-1:0] cls_sr, cls_stage_row;

    row_copy_classify #(.BW(BW), .SW(SW), .LW(LW), .ROWS_PER_SUB(ROWS_PER_SUB)) u_classify (
        .zero(req_zero), .src_bank(req_src_bank), .src_row(req_src_row),
        .dst_bank(req_dst_bank), .dst_row(req_dst_row),
        .mode(cls_mode), .reject(cls_reject),
        .eff_src_bank(cls_sb), .eff_src_row(cls_sr),
        .stage_bank(cls_stage_bank), .stage_row(cls_stage_row)
    );

    typedef struct packed {
        seq_state_e    st;
        logic          twohop;
        logic [BW-1:0] h2_sb;
        logic [RW-1:0] h2_sr;
        logic [BW-1:0] h2_db;
        logic [RW-1:0] h2_dr;
    } seq_regs_t;

    seq_regs_t q, d;
    logic          hop_start, hop_xbank, hop_last;
    logic [BW-1:0] hop_sb, hop_db;
    logic [RW-1:0] hop_sr, hop_dr;
    cmd_op_e       hop_op;

    always_comb begin
        d         = q;
        hop_start = 1'b0;
        hop_xbank = 1'b0;
        hop_sb    = cls_sb;
        hop_sr    = cls_sr;
        hop_db    = req_dst_bank;
        hop_dr    = req_dst_row;
        case (q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    if (cls_reject) begin
                        d.st = SQ_REJECT;
                    end else begin
                        hop_start = 1'b1;
                        hop_xbank = (cls_mode != MODE_INTRA);
                        d.st      = SQ_HOP1;
                        d.twohop  = (cls_mode == MODE_TWOHOP);
                        d.h2_sb   = cls_stage_bank;
                        d.h2_sr   = cls_stage_row;
                        d.h2_db   = req_dst_bank;
                        d.h2_dr   = req_dst_row;
                        if (cls_mode == MODE_TWOHOP) begin
                            hop_db = cls_stage_bank;
                            hop_dr = cls_stage_row;
                        end
                    end
                end
            end
            SQ_HOP1: begin
                if (hop_last) begin
                    if (q.twohop) begin
                        hop_start = 1'b1;
                        hop_xbank = 1'b1;
                        hop_sb    = q.h2_sb;
                        hop_sr    = q.h2_sr;
                        hop_db    = q.h2_db;
                        hop_dr    = q.h2_dr;
                        d.st      = SQ_HOP2;
                    end else begin
                        d.st = SQ_DONE;
                    end
                end
            end
            SQ_HOP2:   if (hop_last) d.st = SQ_DONE;
            SQ_DONE:   d.st = SQ_IDLE;
            SQ_REJECT: d.st = SQ_IDLE;
            default:   d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, twohop: 1'b0, h2_sb: '0, h2_sr: '0, h2_db: '0, h2_dr: '0};
        end else begin
            q <= d;
        end
    end

    row_copy_hop #(.BW(BW), .RW(RW), .NCOL(NCOL)) u_hop (
        .clk(clk), .rst_n(rst_n), .start(hop_start), .start_xbank(hop_xbank),
        .start_sb(hop_sb), .start_sr(hop_sr), .start_db(hop_db), .start_dr(hop_dr),
        .cmd_op(hop_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .last(hop_last)
    );

    assign cmd_op    = hop_op;
    assign req_ready = (q.st == SQ_IDLE);
    assign done      = (q.st == SQ_DONE);
    assign err       = (q.st == SQ_REJECT);

    assert_act_pair_same_sub_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_ACT && $past(cmd_op) == CMD_ACT && cmd_bank == $past(cmd_bank))
        |-> (cmd_row[RW-1:LW] == $past(cmd_row[RW-1:LW])));
    assert_no_zero_row_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_ACT && $past(cmd_op) == CMD_ACT) |-> (cmd_row[LW-1:0] != '0));
    assert_reject_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cmd_op == CMD_NOP));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd_op == CMD_NOP));
endmodule

// File: tb/test_row_copy_seq.sv
module test_row_copy_seq;
    import row_copy_pkg::*;
    localparam int NB = 4, NS = 4, RPS = 8, NR = NS * RPS, NC = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_zero = 0, req_ready, done, err;
    logic [1:0] req_src_bank = 0, req_dst_bank = 0, cmd_bank;
    logic [4:0] req_src_row = 0, req_dst_row = 0, cmd_row;
    logic [2:0] cmd_op, cmd_col;

    always #5 clk = ~clk;

    row_copy_seq i_row_copy_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_zero(req_zero), .req_src_bank(req_src_bank), .req_src_row(req_src_row),
        .req_dst_bank(req_dst_bank), .req_dst_row(req_dst_row),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .done(done), .err(err)
    );

    int checks = 0, failures = 0;
    logic [31:0] mem [NB][NR][NC];
    logic [31:0] shadow [NB][NR][NC];
    logic [31:0] rbuf [NB][NC];
    logic [31:0] pipe [4];
    bit open [NB];
    int orow [NB];
    int pw = 0, pr = 0, pcount = 0, max_fly = 0;
    int n_act = 0, n_pre = 0, n_rd = 0, n_wr = 0, viol = 0;
    int pre_log [4];

    // Row-buffer device model driven by the command port.
    always @(posedge clk) begin
        if (rst_n) begin
            case (cmd_op)
                CMD_ACT: begin
                    n_act++;
                    if (!open[cmd_bank]) begin
                        for (int c = 0; c < NC; c++) rbuf[cmd_bank][c] = mem[cmd_bank][cmd_row][c];
                        open[cmd_bank] = 1;
                    end else begin
                        if (int'(cmd_row) / RPS != orow[cmd_bank] / RPS) viol++;
                        for (int c = 0; c < NC; c++) mem[cmd_bank][cmd_row][c] = rbuf[cmd_bank][c];
                    end
                    orow[cmd_bank] = int'(cmd_row);
                end
                CMD_PRE: begin
                    if (!open[cmd_bank]) viol++;
                    if (n_pre < 4) pre_log[n_pre] = int'(cmd_bank);
                    n_pre++;
                    open[cmd_bank] = 0;
                end
                CMD_RD: begin
                    n_rd++;
                    if (!open[cmd_bank] || pcount == 4) viol++;
                    else begin
                        pipe[pw] = rbuf[cmd_bank][cmd_col];
                        pw = (pw + 1) % 4; pcount++;
                        if (pcount > max_fly) max_fly = pcount;
                    end
                end
                CMD_WR: begin
                    n_wr++;
                    if (!open[cmd_bank] || pcount == 0) viol++;
                    else begin
                        rbuf[cmd_bank][cmd_col] = pipe[pr];
                        mem[cmd_bank][orow[cmd_bank]][cmd_col] = pipe[pr];
                        pr = (pr + 1) % 4; pcount--;
                    end
                end
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // 0 reject, 1 same subarray, 2 inter-bank, 3 two-hop
    function automatic int bmode(bit z, int sb, int sr, int db, int dr);
        int dl = dr % RPS;
        if (dl == 0 || dl == RPS - 1) return 0;
        if (z) return 1;
        if (sb == db && sr == dr) return 0;
        if (sb != db) return 2;
        return (sr / RPS == dr / RPS) ? 1 : 3;
    endfunction

    function automatic int exp_lat(int m);
        case (m)
            1: return 4;
            2: return 2 * NC + 5;
            3: return 4 * NC + 9;
            default: return 1;
        endcase
    endfunction

    function automatic int mem_diffs();
        int n = 0;
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    if (mem[b][r][c] !== shadow[b][r][c]) n++;
        return n;
    endfunction

    task automatic do_req(input bit z, input int sb, input int sr, input int db, input int dr,
                          input bit junk, input string rq);
        int m, lat, esb, esr, stb, str;
        string dtag;
        m = bmode(z, sb, sr, db, dr);
        dtag = (m == 0) ? "R7" : (z ? "R5" : "R2");
        n_act = 0; n_pre = 0; n_rd = 0; n_wr = 0; viol = 0; max_fly = 0;
        @(negedge clk);
        req_valid = 1; req_zero = z;
        req_src_bank = 2'(sb); req_src_row = 5'(sr);
        req_dst_bank = 2'(db); req_dst_row = 5'(dr);
        @(negedge clk);
        if (junk) begin
            req_zero = 0; req_src_bank = 2'(db); req_src_row = 5'(dr);
            req_dst_bank = 2'(sb ^ 2); req_dst_row = 5'((sr & 24) | 3);
        end else req_valid = 0;
        lat = 1;
        while (!done && !err && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        req_valid = 0;
        if (m == 0) begin
            chk(err === 1'b1 && lat == 1, "R7", "reject latency", lat, 1);
        end else begin
            chk(done === 1'b1 && lat == exp_lat(m), rq, "done latency", lat, exp_lat(m));
        end
        chk(n_act == (m == 1 ? 2 : m == 2 ? 2 : m == 3 ? 4 : 0), rq, "ACT count", n_act,
            (m == 1 ? 2 : m == 2 ? 2 : m == 3 ? 4 : 0));
        chk(n_pre == (m == 1 ? 1 : m == 2 ? 2 : m == 3 ? 4 : 0), rq, "PRE count", n_pre,
            (m == 1 ? 1 : m == 2 ? 2 : m == 3 ? 4 : 0));
        chk(n_rd == n_wr && n_rd == (m == 2 ? NC : m == 3 ? 2 * NC : 0), rq, "burst count",
            n_rd, (m == 2 ? NC : m == 3 ? 2 * NC : 0));
        chk(viol == 0, rq, "device protocol violations", viol, 0);
        if (m >= 2) chk(max_fly == 2, "R3", "bursts in flight", max_fly, 2);
        if (m == 2) chk(pre_log[0] == sb && pre_log[1] == db, "R3", "PRE order src bank",
                        pre_log[0], sb);
        if (m != 0) begin
            esb = z ? db : sb;
            esr = z ? (dr / RPS) * RPS : sr;
            if (m == 3) begin
                stb = sb ^ 1; str = RPS - 1;
                for (int c = 0; c < NC; c++) shadow[stb][str][c] = shadow[esb][esr][c];
            end
            for (int c = 0; c < NC; c++) shadow[db][dr][c] = shadow[esb][esr][c];
        end
        chk(mem_diffs() == 0, dtag, "row contents mismatches", mem_diffs(), 0);
        @(negedge clk);
        chk(req_ready === 1'b1, "R8", "ready after completion", int'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int b = 0; b < NB; b++) begin
            open[b] = 0; orow[b] = 0;
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++) begin
                    mem[b][r][c] = (r % RPS == 0) ? 32'd0 : $urandom;
                    shadow[b][r][c] = mem[b][r][c];
                end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1 && cmd_op === 3'd0 && done === 1'b0 && err === 1'b0,
            "R9", "reset outputs ready", int'(req_ready), 1);

        do_req(0, 1, 10, 1, 12, 0, "R1");   // same bank, subarray 1
        do_req(0, 0, 3, 2, 20, 0, "R3");    // different banks
        do_req(0, 2, 5, 2, 29, 0, "R4");    // same bank, subarray 0 -> 3
        do_req(1, 3, 2, 0, 14, 0, "R5");    // zero fill
        do_req(1, 3, 2, 0, 14, 0, "R5");    // zero fill again, junk src fields
        do_req(0, 1, 2, 3, 16, 0, "R7");    // dst is a zero row
        do_req(0, 1, 2, 3, 23, 0, "R7");    // dst is a staging row
        do_req(0, 2, 9, 2, 9, 0, "R7");     // src equals dst
        do_req(0, 0, 4, 1, 5, 1, "R8");     // second request held while busy
        do_req(0, 3, 17, 3, 1, 1, "R8");    // two-hop while busy

        for (int i = 0; i < 40; i++) begin
            do_req(bit'($urandom_range(0, 3) == 0), int'($urandom_range(0, NB - 1)),
                   int'($urandom_range(0, NR - 1)), int'($urandom_range(0, NB - 1)),
                   int'($urandom_range(0, NR - 1)), 0, "R6");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule